// File: doc/BRIEF.md
# Reference Path Mode Controller

This block governs the reference side of a frequency synthesizer from a single 3-bit mode code. The code chooses between three things: a fully stopped reference path, a running crystal oscillator, and an externally driven reference whose buffered copy is passed on at a power-of-two fraction of the input rate or withheld. A standby input pauses the reference divider (the R counter) while leaving the oscillator alone. The block drives the enable flags for the crystal amplifier and the R counter. The crystal amplifier and the R counter are outside the block.

The buffered reference output is produced as a clock enable in the reference clock domain. It is high for one reference cycle in every D cycles, where D is the selected ratio. For a ratio of one it is high on every cycle. A downstream clock gate or an enable-qualified register turns it into the divided reference. A change of mode code is applied only at the divider's terminal count. This ensures that no shortened interval appears on the output. Out of reset the divider runs at ratio 8, whatever code is applied.

Top module: `refosc_ctrl`

## Requirements
- R1: `osc_en` is high exactly when `mode_code` is 1 (crystal running), whatever the level of `standby`.
- R2: With `mode_code` 0 (shutdown), `osc_en` and `rcnt_en` are both low, whatever the level of `standby`.
- R3: `rcnt_en` is high when `mode_code` is non-zero and `standby` is low. It is low whenever `standby` is high.
- R4: Each mode code selects a reference-output ratio D. Code 3 gives D=1, code 4 gives D=2, code 5 gives D=4, code 6 gives D=8 and code 7 gives D=16. With codes 0, 1 and 2 the output is disabled. After the first terminal count, a disabled output stays low. `standby` has no effect on `ref_out`.
- R5: While a ratio D is active, `ref_out` is high for exactly one cycle in every D cycles. When D=1 it is high on every cycle.
- R6: Reset is synchronous and active low. While `rst_n` is low, `ref_out` is low and the divider is set to ratio 8, enabled. After the release, `ref_out` is first high in the cycle that follows the seventh rising edge sampled with `rst_n` high.
- R7: A new code is adopted only on the rising edge that ends a terminal-count cycle. A change made during an interval does not alter that interval. Consider a disabled output: every cycle is a terminal count. A code enabling ratio D is adopted on the next edge. `ref_out` first goes high D-1 cycles after that edge, which for D=1 is the cycle right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_code | input | 3 | Reference path mode code |
| standby | input | 1 | Standby request; halts the R counter |
| ref_out | output | 1 | Divided reference as a one-cycle clock enable |
| osc_en | output | 1 | Crystal oscillator amplifier enable |
| rcnt_en | output | 1 | R counter enable |

## Verification
The assertions assume several things about the inputs. `mode_code` and `standby` are synchronous to `clk_ref` and settle before each rising edge. Reset is held low for at least one edge before the block is used. The divider checks also assume that the mode code is only ever read at a terminal count. The stimulus is built to stay within these limits. It changes `mode_code`, `standby` and `rst_n` only at falling edges and holds reset across two rising edges. The sweep covers every code with both standby levels. A further sequence switches codes in the middle of intervals, so that the deferred adoption at terminal counts can be observed at the output.

// File: rtl/refosc_pkg.sv
// Package: refosc_pkg
// Shared mode code encoding for the reference path controller.
// Assumes a 3-bit mode code; the numeric values are fixed by the
// divider selection rule (ratio exponent = code - 3 for codes 3..7).
package refosc_pkg;

    localparam int CODE_W = 3;

    typedef enum logic [CODE_W-1:0] {
        RMODE_SHUTDOWN  = 3'd0,
        RMODE_XTAL      = 3'd1,
        RMODE_REF_QUIET = 3'd2,
        RMODE_REF_DIV1  = 3'd3,
        RMODE_REF_DIV2  = 3'd4,
        RMODE_REF_DIV4  = 3'd5,
        RMODE_REF_DIV8  = 3'd6,
        RMODE_REF_DIV16 = 3'd7
    } refmode_e;

    // Lowest code that enables the buffered reference output.
    localparam logic [CODE_W-1:0] FIRST_DIV_CODE = RMODE_REF_DIV1;

endpackage

// File: rtl/refosc_mode_decode.sv
// Module: refosc_mode_decode
// Turns the mode code and standby flag into the oscillator enable,
// the R counter enable and the requested output-divider setting.
// Purely combinational; assumes inputs are synchronous to the
// reference clock. Ratio exponents above MAX_LOG2 are clamped.
module refosc_mode_decode
    import refosc_pkg::*;
#(
    parameter int MAX_LOG2 = 4,
    localparam int LOG2_W  = $clog2(MAX_LOG2 + 1)
) (
    input  logic [CODE_W-1:0] mode_code,
    input  logic              standby,
    output logic              osc_en,
    output logic              rcnt_en,
    output logic              req_on,
    output logic [LOG2_W-1:0] req_log2
);

    refmode_e            mode;
    logic [CODE_W-1:0]   exp_raw;

    // Interpret the raw code as a mode.
    always_comb mode = refmode_e'(mode_code);

    // Amplifier and R counter enables.
    always_comb begin
        osc_en  = (mode == RMODE_XTAL);
        rcnt_en = (mode != RMODE_SHUTDOWN) && !standby;
    end

    // Requested output ratio: off below the first divide code, else 2^(code-3).
    always_comb begin
        exp_raw  = mode_code - FIRST_DIV_CODE;
        req_on   = (mode_code >= FIRST_DIV_CODE);
        req_log2 = '0;
        if (req_on) begin
            if (int'(exp_raw) > MAX_LOG2) req_log2 = LOG2_W'(MAX_LOG2);
            else                          req_log2 = LOG2_W'(exp_raw);
        end
    end

endmodule

// File: rtl/refosc_divider.sv
// Module: refosc_divider
// Power-of-two divider that emits a one-cycle enable per interval.
// The active setting is loaded only at the terminal count, so a
// setting change never shortens an interval. A disabled setting runs
// at ratio 1 internally so that a re-enable is adopted on the next
// edge. Assumes synchronous active-low reset held for one edge.
module refosc_divider #(
    parameter int MAX_LOG2   = 4,
    parameter int PWRUP_LOG2 = 3,
    localparam int LOG2_W    = $clog2(MAX_LOG2 + 1),
    localparam int CNT_W     = (MAX_LOG2 < 1) ? 1 : MAX_LOG2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_on,
    input  logic [LOG2_W-1:0] req_log2,
    output logic              tick
);

    logic [CNT_W-1:0]  count;
    logic              act_on;
    logic [LOG2_W-1:0] act_log2;
    logic [MAX_LOG2:0] hit;
    logic              term;
    logic [CNT_W-1:0]  limit;
    logic              past_ok;

    // Terminal detection: one comparator per supported exponent.
    for (genvar k = 0; k <= MAX_LOG2; k++) begin : g_term
        if (k == 0) begin : g_unit
            assign hit[k] = (act_log2 == LOG2_W'(k));
        end else begin : g_pow
            assign hit[k] = (act_log2 == LOG2_W'(k)) && (&count[k-1:0]);
        end
    end

    // Any selected comparator firing marks the last cycle of an interval.
    always_comb term = |hit;

    // Output enable: last cycle of an interval while output is on.
    always_comb tick = act_on && term;

    // Interval counter and setting register, updated at terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count    <= '0;
            act_on   <= 1'b1;
            act_log2 <= LOG2_W'(PWRUP_LOG2);
        end else if (term) begin
            count    <= '0;
            act_on   <= req_on;
            act_log2 <= req_on ? req_log2 : '0;
        end else begin
            count    <= count + 1'b1;
        end
    end

    // Arithmetic last count of the interval, for checking only.
    always_comb begin
        limit = '0;
        for (int i = 0; i < CNT_W; i++)
            if (i < int'(act_log2)) limit[i] = 1'b1;
    end

    // Marks cycles whose previous edge was already out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        count <= limit);                                                   // R5
    AST_TICK_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (count == '0));                                           // R5
    AST_SETTING_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(term)) |-> ($stable(act_log2) && $stable(act_on))); // R7
    AST_PWRUP_RATIO: assert property (@(posedge clk)
        !rst_n |=> (act_on && act_log2 == LOG2_W'(PWRUP_LOG2) && count == '0)); // R6

endmodule

// File: rtl/refosc_ctrl.sv
// Module: refosc_ctrl (top)
// Reference path controller: decodes the mode code into oscillator and
// R counter enables and drives a power-of-two divided reference enable.
// Assumes mode_code and standby are synchronous to clk_ref.
module refosc_ctrl #(
    parameter int MAX_LOG2   = 4,
    parameter int PWRUP_LOG2 = 3,
    localparam int LOG2_W    = $clog2(MAX_LOG2 + 1)
) (
    input  logic       clk_ref,
    input  logic       rst_n,
    input  logic [2:0] mode_code,
    input  logic       standby,
    output logic       ref_out,
    output logic       osc_en,
    output logic       rcnt_en
);

    logic              req_on;
    logic [LOG2_W-1:0] req_log2;

    // Mode code decode.
    refosc_mode_decode #(.MAX_LOG2(MAX_LOG2)) u_decode (
        .mode_code (mode_code),
        .standby   (standby),
        .osc_en    (osc_en),
        .rcnt_en   (rcnt_en),
        .req_on    (req_on),
        .req_log2  (req_log2)
    );

    // Reference output divider.
    refosc_divider #(.MAX_LOG2(MAX_LOG2), .PWRUP_LOG2(PWRUP_LOG2)) u_div (
        .clk      (clk_ref),
        .rst_n    (rst_n),
        .req_on   (req_on),
        .req_log2 (req_log2),
        .tick     (ref_out)
    );

    AST_OSC_ONLY_XTAL: assert property (@(posedge clk_ref) disable iff (!rst_n)
        osc_en |-> (mode_code == 3'd1));                                   // R1
    AST_SHUTDOWN_QUIET: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (mode_code == 3'd0) |-> (!osc_en && !rcnt_en));                    // R2
    AST_STANDBY_HALTS: assert property (@(posedge clk_ref) disable iff (!rst_n)
        standby |-> !rcnt_en);                                             // R3
    AST_RESET_QUIET: assert property (@(posedge clk_ref)
        !rst_n |=> !ref_out);                                              // R6

endmodule

// File: tb/sim_refosc_ctrl.sv
module sim_refosc_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode_code = 3'd0;
    logic       standby = 1'b0;
    logic       ref_out, osc_en, rcnt_en;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    refosc_ctrl u0 (
        .clk_ref   (clk),
        .rst_n     (rst_n),
        .mode_code (mode_code),
        .standby   (standby),
        .ref_out   (ref_out),
        .osc_en    (osc_en),
        .rcnt_en   (rcnt_en)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp_v, $time);
        end
    endtask

    // Hold reset over two edges, then release at a falling edge (idx 0).
    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(ref_out == 1'b0, "R6 reset ref_out", ref_out, 0);
        rst_n = 1'b1;
    endtask

    // Sweep one code/standby pair from reset and check every cycle.
    task automatic sweep(input int code, input bit sb);
        int d;
        bit on;
        bit e;
        mode_code = 3'(code);
        standby   = sb;
        do_reset();
        on = (code >= 3);
        d  = on ? (1 << (code - 3)) : 1;
        chk(osc_en == (code == 1), "R1 osc_en", osc_en, int'(code == 1));
        chk(rcnt_en == (code != 0 && !sb), "R3 rcnt_en", rcnt_en, int'(code != 0 && !sb));
        if (code == 0) chk(!osc_en && !rcnt_en, "R2 shutdown", {osc_en, rcnt_en}, 0);
        for (int idx = 0; idx <= 60; idx++) begin
            if (idx > 0) @(negedge clk);
            e = (idx == 7) || (on && idx > 7 && ((idx - 7) % d) == 0);
            if (idx <= 7) chk(ref_out == e, "R6 power-up ratio", ref_out, int'(e));
            else if (on)  chk(ref_out == e, "R5 pulse spacing", ref_out, int'(e));
            else          chk(ref_out == e, "R4 disabled output", ref_out, int'(e));
        end
    endtask

    initial begin
        bit e;
        for (int c = 0; c < 8; c++)
            for (int s = 0; s < 2; s++)
                sweep(c, s[0]);

        // R7: code changes in mid-interval take effect at terminal count.
        mode_code = 3'd7;
        standby   = 1'b0;
        do_reset();
        for (int idx = 0; idx <= 50; idx++) begin
            if (idx > 0) @(negedge clk);
            e = (idx == 7) || (idx == 23) || (idx == 25) || (idx == 27)
                || (idx == 29) || (idx >= 41);
            chk(ref_out == e, "R7 deferred switch", ref_out, int'(e));
            if (idx == 10) mode_code = 3'd4;
            if (idx == 28) mode_code = 3'd2;
            if (idx == 40) mode_code = 3'd3;
        end

        // R4: standby toggling during a running ratio leaves ref_out alone.
        mode_code = 3'd5;
        do_reset();
        for (int idx = 0; idx <= 40; idx++) begin
            if (idx > 0) @(negedge clk);
            e = (idx == 7) || (idx > 7 && ((idx - 7) % 4) == 0);
            chk(ref_out == e, "R4 standby no effect", ref_out, int'(e));
            chk(rcnt_en == !standby, "R3 standby toggle", rcnt_en, int'(!standby));
            standby = idx[1];
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule